// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Decoder

This block is the purely combinational front end of a small 32-bit single-cycle processor. Each cycle it receives the program counter, a window of six instruction bytes starting at that address, and a flag that marks the fetch as faulted. From these it produces the split opcode byte, the two register specifiers, the constant word, the address of the next sequential instruction, and three flags. The flags say whether the opcode is legal, whether a register byte follows the opcode, and whether a 4-byte constant is present.

Instructions are 1, 2, 5 or 6 bytes long. Whether an opcode carries a register byte and whether it carries a constant is fixed per opcode, and those two flags set both where the constant starts and how far the PC advances. A faulted fetch is turned into a harmless no-op so that the later stages see a legal instruction. The block holds no state: there is no state machine, no register and no reset. The house style's state-register and output processes therefore reduce to a single classification step, followed by a field-alignment step and an adder.

Window layout: byte k of the window (the byte at PC+k) occupies bits [8k+7:8k] of `imem_win_i`. Opcode numbering is halt 0x0, nop 0x1, register move 0x2, immediate move 0x3, register-to-memory 0x4, memory-to-register 0x5, ALU op 0x6, conditional jump 0x7, call 0x8, return 0x9, push 0xA, pop 0xB.

Top module: `instr_fetch`

## Requirements
- R1: With no fault, `icode_o` equals bits [7:4] of byte 0 and `ifun_o` equals bits [3:0] of byte 0.
- R2: With `imem_fault_i` high, `icode_o` is 0x1 (nop), `ifun_o` is 0x0, `instr_valid_o` is 1, both presence flags are 0, `ra_o` and `rb_o` are 0xF, `valc_o` is 0 and `valp_o` is PC+1, whatever the window holds.
- R3: `need_regs_o` is 1 exactly for opcodes 0x2, 0x3, 0x4, 0x5, 0x6, 0xA and 0xB.
- R4: When `need_regs_o` is 1, `ra_o` is bits [7:4] of byte 1 and `rb_o` is bits [3:0] of byte 1. Otherwise both read 0xF.
- R5: `need_const_o` is 1 exactly for opcodes 0x3, 0x4, 0x5, 0x7 and 0x8.
- R6: When `need_const_o` is 1, `valc_o` is the little-endian word made of bytes 1..4 if `need_regs_o` is 0, and of bytes 2..5 if `need_regs_o` is 1. The lowest-addressed byte is the least significant.
- R7: When `need_const_o` is 0, `valc_o` is 0.
- R8: `instr_valid_o` is 1 for opcodes 0x0 to 0xB and 0 for 0xC to 0xF. An invalid opcode clears both presence flags.
- R9: `valp_o` equals PC + 1 + `need_regs_o` + 4·`need_const_o`, modulo 2^32. This gives PC+1 for return, PC+2 for register-only forms, PC+5 for jump and call, and PC+6 for constant forms with registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 32 | Address of the instruction being fetched |
| imem_win_i | input | 48 | Instruction bytes PC..PC+5, byte k in bits [8k+7:8k] |
| imem_fault_i | input | 1 | Instruction memory reported an error for this fetch |
| icode_o | output | 4 | Instruction code |
| ifun_o | output | 4 | Function code |
| ra_o | output | 4 | First register specifier, 0xF when absent |
| rb_o | output | 4 | Second register specifier, 0xF when absent |
| valc_o | output | 32 | Constant word, 0 when absent |
| valp_o | output | 32 | Fall-through address |
| instr_valid_o | output | 1 | Opcode is legal |
| need_regs_o | output | 1 | Register byte present |
| need_const_o | output | 1 | Constant word present |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a 32-bit constant and a six-byte window. With these values the longest encoding fills the window exactly, so both constant offsets and every byte lane are reached. Random windows cover all sixteen opcode values, with faults injected among them. Directed cases pin the fault substitution over a window full of ones, a six-byte instruction whose next address wraps past the top of the address space, and a wide constant whose bytes are all distinct, so a swapped lane shows up.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

    typedef enum logic [3:0] {
        OP_HALT  = 4'h0,
        OP_NOP   = 4'h1,
        OP_RRMOV = 4'h2,
        OP_IRMOV = 4'h3,
        OP_RMMOV = 4'h4,
        OP_MRMOV = 4'h5,
        OP_ALU   = 4'h6,
        OP_JUMP  = 4'h7,
        OP_CALL  = 4'h8,
        OP_RET   = 4'h9,
        OP_PUSH  = 4'hA,
        OP_POP   = 4'hB
    } opcode_e;

    localparam logic [3:0] FN_NONE  = 4'h0;
    localparam logic [3:0] REG_NONE = 4'hF;

    typedef struct packed {
        logic legal;
        logic has_regs;
        logic has_const;
    } op_class_t;

endpackage

// File: rtl/fetch_classify.sv
module fetch_classify
    import fetch_pkg::*;
(
    input  logic [3:0] code_i,
    output op_class_t  cls_o
);
    always_comb begin
        cls_o = '{legal: 1'b0, has_regs: 1'b0, has_const: 1'b0};
        case (code_i)
            OP_HALT, OP_NOP, OP_RET:
                cls_o = '{legal: 1'b1, has_regs: 1'b0, has_const: 1'b0};
            OP_RRMOV, OP_ALU, OP_PUSH, OP_POP:
                cls_o = '{legal: 1'b1, has_regs: 1'b1, has_const: 1'b0};
            OP_IRMOV, OP_RMMOV, OP_MRMOV:
                cls_o = '{legal: 1'b1, has_regs: 1'b1, has_const: 1'b1};
            OP_JUMP, OP_CALL:
                cls_o = '{legal: 1'b1, has_regs: 1'b0, has_const: 1'b1};
            default:
                cls_o = '{legal: 1'b0, has_regs: 1'b0, has_const: 1'b0};
        endcase
    end
endmodule

// File: rtl/fetch_align.sv
module fetch_align
    import fetch_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int TAIL_BYTES = 5
) (
    input  logic [8*TAIL_BYTES-1:0] tail_i,
    input  logic                    has_regs_i,
    input  logic                    has_const_i,
    output logic [3:0]              ra_o,
    output logic [3:0]              rb_o,
    output logic [WORD_W-1:0]       valc_o
);
    localparam int CONST_BYTES = WORD_W / 8;

    logic [WORD_W-1:0] word_near;
    logic [WORD_W-1:0] word_far;

    for (genvar k = 0; k < CONST_BYTES; k++) begin : g_lane
        assign word_near[8*k +: 8] = tail_i[8*k +: 8];
        assign word_far[8*k +: 8]  = tail_i[8*(k+1) +: 8];
    end

    always_comb begin
        ra_o = has_regs_i ? tail_i[7:4] : REG_NONE;
        rb_o = has_regs_i ? tail_i[3:0] : REG_NONE;
        if (!has_const_i)
            valc_o = '0;
        else if (has_regs_i)
            valc_o = word_far;
        else
            valc_o = word_near;
    end
endmodule

// File: rtl/fetch_next_pc.sv
module fetch_next_pc #(
    parameter int ADDR_W      = 32,
    parameter int CONST_BYTES = 4
) (
    input  logic [ADDR_W-1:0] pc_i,
    input  logic              has_regs_i,
    input  logic              has_const_i,
    output logic [ADDR_W-1:0] valp_o
);
    logic [ADDR_W-1:0] span;

    always_comb begin
        span = ADDR_W'(1) + ADDR_W'(has_regs_i);
        if (has_const_i)
            span = span + ADDR_W'(CONST_BYTES);
        valp_o = pc_i + span;
    end
endmodule

// File: rtl/instr_fetch.sv
module instr_fetch
    import fetch_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int WORD_W    = 32,
    parameter int WIN_BYTES = 6
) (
    input  logic [ADDR_W-1:0]      pc_i,
    input  logic [8*WIN_BYTES-1:0] imem_win_i,
    input  logic                   imem_fault_i,
    output logic [3:0]             icode_o,
    output logic [3:0]             ifun_o,
    output logic [3:0]             ra_o,
    output logic [3:0]             rb_o,
    output logic [WORD_W-1:0]      valc_o,
    output logic [ADDR_W-1:0]      valp_o,
    output logic                   instr_valid_o,
    output logic                   need_regs_o,
    output logic                   need_const_o
);
    localparam int CONST_BYTES = WORD_W / 8;
    localparam int TAIL_BYTES  = WIN_BYTES - 1;

    op_class_t cls;

    always_comb begin
        if (imem_fault_i) begin
            icode_o = OP_NOP;
            ifun_o  = FN_NONE;
        end else begin
            icode_o = imem_win_i[7:4];
            ifun_o  = imem_win_i[3:0];
        end
    end

    fetch_classify i_classify (
        .code_i (icode_o),
        .cls_o  (cls)
    );

    assign instr_valid_o = cls.legal;
    assign need_regs_o   = cls.has_regs;
    assign need_const_o  = cls.has_const;

    fetch_align #(
        .WORD_W     (WORD_W),
        .TAIL_BYTES (TAIL_BYTES)
    ) i_align (
        .tail_i      (imem_win_i[8*WIN_BYTES-1:8]),
        .has_regs_i  (cls.has_regs),
        .has_const_i (cls.has_const),
        .ra_o        (ra_o),
        .rb_o        (rb_o),
        .valc_o      (valc_o)
    );

    fetch_next_pc #(
        .ADDR_W      (ADDR_W),
        .CONST_BYTES (CONST_BYTES)
    ) i_next_pc (
        .pc_i        (pc_i),
        .has_regs_i  (cls.has_regs),
        .has_const_i (cls.has_const),
        .valp_o      (valp_o)
    );
endmodule

// File: rtl/instr_fetch_chk.sv
module instr_fetch_chk #(
    parameter int ADDR_W    = 32,
    parameter int WORD_W    = 32,
    parameter int WIN_BYTES = 6
) (
    input logic [ADDR_W-1:0]      pc_i,
    input logic [8*WIN_BYTES-1:0] imem_win_i,
    input logic                   imem_fault_i,
    input logic [3:0]             icode_o,
    input logic [3:0]             ifun_o,
    input logic [3:0]             ra_o,
    input logic [3:0]             rb_o,
    input logic [WORD_W-1:0]      valc_o,
    input logic [ADDR_W-1:0]      valp_o,
    input logic                   instr_valid_o,
    input logic                   need_regs_o,
    input logic                   need_const_o
);
    localparam int CONST_BYTES = WORD_W / 8;

    logic [ADDR_W-1:0] span_seen;
    logic              unused_win;

    assign span_seen  = valp_o - pc_i;
    assign unused_win = ^{imem_win_i, ifun_o};

    always_comb begin
        if (imem_fault_i) begin
            assert_fault_nop_R2: assert (icode_o == 4'h1 && instr_valid_o && !need_regs_o && !need_const_o)
                else $error("fault did not yield a plain nop");
        end
        if (!need_regs_o) begin
            assert_no_regs_R4: assert (ra_o == 4'hF && rb_o == 4'hF)
                else $error("register specifiers not 0xF without a register byte");
        end
        if (!need_const_o) begin
            assert_no_const_R7: assert (valc_o == '0)
                else $error("constant nonzero without a constant word");
        end
        if (!instr_valid_o) begin
            assert_invalid_bare_R8: assert (!need_regs_o && !need_const_o)
                else $error("illegal opcode carries presence flags");
        end
        assert_length_R9: assert (span_seen == ADDR_W'(1) + ADDR_W'(need_regs_o)
                                  + (need_const_o ? ADDR_W'(CONST_BYTES) : '0))
            else $error("next address does not match instruction length");
    end
endmodule

bind instr_fetch instr_fetch_chk #(
    .ADDR_W    (ADDR_W),
    .WORD_W    (WORD_W),
    .WIN_BYTES (WIN_BYTES)
) i_chk (
    .pc_i          (pc_i),
    .imem_win_i    (imem_win_i),
    .imem_fault_i  (imem_fault_i),
    .icode_o       (icode_o),
    .ifun_o        (ifun_o),
    .ra_o          (ra_o),
    .rb_o          (rb_o),
    .valc_o        (valc_o),
    .valp_o        (valp_o),
    .instr_valid_o (instr_valid_o),
    .need_regs_o   (need_regs_o),
    .need_const_o  (need_const_o)
);

// File: tb/test_instr_fetch.sv
`timescale 1ns/1ps
module test_instr_fetch;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pc;
    logic [47:0] win;
    logic        fault;
    logic [3:0]  icode, ifun, ra, rb;
    logic [31:0] valc, valp;
    logic        valid, nregs, nconst;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    instr_fetch i_instr_fetch (
        .pc_i          (pc),
        .imem_win_i    (win),
        .imem_fault_i  (fault),
        .icode_o       (icode),
        .ifun_o        (ifun),
        .ra_o          (ra),
        .rb_o          (rb),
        .valc_o        (valc),
        .valp_o        (valp),
        .instr_valid_o (valid),
        .need_regs_o   (nregs),
        .need_const_o  (nconst)
    );

    function automatic bit m_regs(input logic [3:0] c);
        return c inside {4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'hA, 4'hB};
    endfunction
    function automatic bit m_const(input logic [3:0] c);
        return c inside {4'h3, 4'h4, 4'h5, 4'h7, 4'h8};
    endfunction
    function automatic bit m_valid(input logic [3:0] c);
        return c <= 4'hB;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] p, input logic [47:0] w, input logic f);
        logic [3:0]  c, fn;
        bit          er, ec;
        logic [31:0] ev;
        @(posedge clk);
        pc = p; win = w; fault = f;
        @(negedge clk);
        c  = f ? 4'h1 : w[7:4];
        fn = f ? 4'h0 : w[3:0];
        er = m_regs(c);
        ec = m_const(c);
        if (!ec)     ev = 32'h0;
        else if (er) ev = w[47:16];
        else         ev = w[39:8];
        chk(f ? "R2" : "R1", "icode", {28'h0, icode}, {28'h0, c});
        chk(f ? "R2" : "R1", "ifun",  {28'h0, ifun},  {28'h0, fn});
        chk("R3", "need_regs",  {31'h0, nregs},  {31'h0, er});
        chk("R5", "need_const", {31'h0, nconst}, {31'h0, ec});
        chk("R4", "ra", {28'h0, ra}, {28'h0, er ? w[15:12] : 4'hF});
        chk("R4", "rb", {28'h0, rb}, {28'h0, er ? w[11:8]  : 4'hF});
        chk(ec ? "R6" : "R7", "valc", valc, ev);
        chk("R8", "valid", {31'h0, valid}, {31'h0, m_valid(c)});
        chk("R9", "valp", valp, p + 32'd1 + {31'h0, er} + (ec ? 32'd4 : 32'd0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        pc = 32'h0; win = 48'h0; fault = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Idle state after reset: all-zero window decodes as halt at PC 0 (R1, R9)
        apply(32'h0, 48'h0, 1'b0);
        // Every opcode value once, with a window of distinct bytes (R3, R5, R8)
        for (int c = 0; c < 16; c++)
            apply(32'h0000_1000, {40'hA1B2_C3D4_E5, 4'(c), 4'h3}, 1'b0);
        // R2: fault over a window full of ones
        apply(32'h0000_2000, 48'hFFFF_FFFF_FFFF, 1'b1);
        // R9: six-byte form wrapping past the top of the address space
        apply(32'hFFFF_FFFD, 48'h8877_6655_1230, 1'b0);
        // R6: call with distinct constant bytes, constant at PC+1
        apply(32'h0000_0040, 48'h0099_DDCC_BBAA_80, 1'b0);
        // R6: memory load, constant at PC+2
        apply(32'h0000_0044, 48'h1122_3344_5650, 1'b0);
        // R4, R7: return keeps registers 0xF and constant 0
        apply(32'h0000_0050, 48'hFFFF_FFFF_FF90, 1'b0);
        for (int i = 0; i < 1500; i++) begin
            logic [47:0] w;
            w = {$urandom(), $urandom()} [47:0];
            apply($urandom(), w, ($urandom() % 8) == 0);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule